// File: doc/BRIEF.md
# Supply Supervisor and Reset Sequencer

This block is the digital half of a power-management supervisor. Four analog comparators report supply faults to it: the battery is low, the input supply is over-voltage, the main rail is over-voltage, and the main rail is under-voltage. From these flags it drives the enable of the always-on main regulator, a battery-good output and an active-low CPU reset. Comparator hysteresis belongs to the analog side; this logic treats every flag as a clean level once it has been synchronised.

The main regulator runs only when none of its three interlocks is active: battery low, input over-voltage and rail over-voltage. A rail over-voltage event turns the regulator off until the flag clears. The regulator then turns on again, so the block retries until the rail settles. The CPU reset is released a programmable number of system clock cycles after the rail leaves under-voltage. It is reasserted as soon as the rail drops back below the threshold. If the rail dips while the delay is still counting, the count restarts from zero. While reset is held, an internal logic reset is high and the control inputs from the rest of the chip are forced to zero, so that no command gets through.

Top module: `supply_supervisor`

## Requirements
- R1: While rst_ni is low, and right after it rises, rail_en_o=0, batt_good_o=0, cpu_rst_no=0, logic_rst_o=1 and ctrl_o is all zero.
- R2: Each fault input is synchronised by two flops. A change on an input is not visible on any output until the third rising clock edge after it.
- R3: When batt_low_i=1 (1 means battery below threshold), batt_good_o and rail_en_o fall on the third edge after the change. cpu_rst_no does not change because of it.
- R4: When batt_low_i falls to 0 while both over-voltage inputs are 0, batt_good_o and rail_en_o rise on the third edge.
- R5: While vin_ov_i=1, rail_en_o is 0 and batt_good_o is unaffected. Clearing the flag restores rail_en_o on the third edge.
- R6: rail_ov_i=1 turns rail_en_o off. Clearing it turns rail_en_o back on, and this repeats on every toggle of the flag.
- R7: After rail_uv_i falls to 0, cpu_rst_no stays low for DELAY_CYCLES+1 rising edges and rises on edge DELAY_CYCLES+2.
- R8: When rail_uv_i rises to 1, cpu_rst_no falls on the third rising edge, with no delay count.
- R9: If rail_uv_i returns to 1 before the release, the delay count restarts. A full DELAY_CYCLES+2 edges are then needed after the final clearing.
- R10: logic_rst_o is the inverse of cpu_rst_no. While it is 1, ctrl_o is all zero. Otherwise ctrl_o equals ctrl_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| batt_low_i | input | 1 | Battery-low comparator, 1 = low |
| vin_ov_i | input | 1 | Input supply over-voltage, 1 = fault |
| rail_ov_i | input | 1 | Main rail over-voltage, 1 = fault |
| rail_uv_i | input | 1 | Main rail under-voltage, 1 = below threshold |
| ctrl_i | input | CTRL_W | Control inputs from pins and serial interface |
| rail_en_o | output | 1 | Main regulator enable |
| batt_good_o | output | 1 | Battery-good indicator |
| cpu_rst_no | output | 1 | CPU reset, active low |
| logic_rst_o | output | 1 | Internal logic reset, active high |
| ctrl_o | output | CTRL_W | Gated control inputs |

## Verification
The assertions assume that each comparator flag is an asynchronous level that stays put for at least a few clocks, so that the synchronised copy follows it without being missed. The stimulus changes flags only just after a falling edge and holds each value for at least three cycles. The bench shortens DELAY_CYCLES to 20 so that the release window, and a restart inside it, can be measured edge by edge.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned F_BATT_LOW = 0;
  localparam int unsigned F_VIN_OV   = 1;
  localparam int unsigned F_RAIL_OV  = 2;
  localparam int unsigned F_RAIL_UV  = 3;
  // safe state: battery low and rail under-voltage until proven otherwise
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 4'b1001;

  typedef struct packed {
    logic rail_uv;
    logic rail_ov;
    logic vin_ov;
    logic batt_low;
  } flags_t;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/rail_interlock.sv
module rail_interlock
  import supv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t flags_i,
  output logic   rail_en_o,
  output logic   batt_good_o
);
  logic en_q, good_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      good_q <= 1'b0;
    end else begin
      good_q <= ~flags_i.batt_low;
      // rail over-voltage retry falls out of re-evaluating each cycle
      en_q   <= ~(flags_i.batt_low | flags_i.vin_ov | flags_i.rail_ov);
    end
  end

  assign rail_en_o   = en_q;
  assign batt_good_o = good_q;
endmodule

// File: rtl/reset_delay.sv
module reset_delay #(
  parameter int unsigned DELAY_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_uv_i,
  output logic released_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (rail_uv_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign released_o = rel_q;
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supv_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 5_000_000,
  parameter int unsigned CTRL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              batt_low_i,
  input  logic              vin_ov_i,
  input  logic              rail_ov_i,
  input  logic              rail_uv_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              rail_en_o,
  output logic              batt_good_o,
  output logic              cpu_rst_no,
  output logic              logic_rst_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [NUM_FLAGS-1:0] raw_flags, sync_flags;
  flags_t flags_s;
  logic   released;

  assign raw_flags[F_BATT_LOW] = batt_low_i;
  assign raw_flags[F_VIN_OV]   = vin_ov_i;
  assign raw_flags[F_RAIL_OV]  = rail_ov_i;
  assign raw_flags[F_RAIL_UV]  = rail_uv_i;

  flag_sync #(.W(NUM_FLAGS), .RST_VAL(FLAG_RST)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(raw_flags), .sync_o(sync_flags)
  );

  assign flags_s.batt_low = sync_flags[F_BATT_LOW];
  assign flags_s.vin_ov   = sync_flags[F_VIN_OV];
  assign flags_s.rail_ov  = sync_flags[F_RAIL_OV];
  assign flags_s.rail_uv  = sync_flags[F_RAIL_UV];

  rail_interlock lock_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .flags_i(flags_s),
    .rail_en_o(rail_en_o), .batt_good_o(batt_good_o)
  );

  reset_delay #(.DELAY_CYCLES(DELAY_CYCLES)) dly_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rail_uv_i(flags_s.rail_uv),
    .released_o(released)
  );

  assign cpu_rst_no  = released;
  assign logic_rst_o = ~released;
  assign ctrl_o      = released ? ctrl_i : '0;
endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk #(
  parameter int unsigned DELAY_CYCLES = 5_000_000,
  parameter int unsigned CTRL_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              batt_low_s,
  input logic              vin_ov_s,
  input logic              rail_ov_s,
  input logic              rail_uv_s,
  input logic              rail_en_o,
  input logic              batt_good_o,
  input logic              cpu_rst_no,
  input logic              logic_rst_o,
  input logic [CTRL_W-1:0] ctrl_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1);
  logic [CNT_W-1:0] ok_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ok_cnt <= '0;
    else if (rail_uv_s)                     ok_cnt <= '0;
    else if (ok_cnt != CNT_W'(DELAY_CYCLES)) ok_cnt <= ok_cnt + 1'b1;
  end

  AST_BATT_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_low_s |=> (!rail_en_o && !batt_good_o)); // R3
  AST_VIN_OV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vin_ov_s |=> !rail_en_o); // R5
  AST_RAIL_OV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rail_ov_s |=> !rail_en_o); // R6
  AST_EN_NEEDS_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rail_en_o |-> batt_good_o); // R4
  AST_RELEASE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> ok_cnt == CNT_W'(DELAY_CYCLES)); // R7
  AST_UV_FAST_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rail_uv_s |=> !cpu_rst_no); // R8
  AST_CTRL_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |-> (ctrl_o == '0 && !cpu_rst_no)); // R10
endmodule

bind supply_supervisor supply_supervisor_chk #(
  .DELAY_CYCLES(DELAY_CYCLES), .CTRL_W(CTRL_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .batt_low_s(flags_s.batt_low), .vin_ov_s(flags_s.vin_ov),
  .rail_ov_s(flags_s.rail_ov), .rail_uv_s(flags_s.rail_uv),
  .rail_en_o(rail_en_o), .batt_good_o(batt_good_o),
  .cpu_rst_no(cpu_rst_no), .logic_rst_o(logic_rst_o), .ctrl_o(ctrl_o)
);

// File: tb/supply_supervisor_tb_top.sv
`timescale 1ns/1ps
module supply_supervisor_tb_top;
  localparam int unsigned D = 20;
  localparam int unsigned CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic batt_low = 1'b1, vin_ov = 1'b0, rail_ov = 1'b0, rail_uv = 1'b1;
  logic [CW-1:0] ctrl = 4'hA;
  logic rail_en, batt_good, cpu_rst_n, logic_rst;
  logic [CW-1:0] ctrl_q;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  supply_supervisor #(.DELAY_CYCLES(D), .CTRL_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .batt_low_i(batt_low), .vin_ov_i(vin_ov),
    .rail_ov_i(rail_ov), .rail_uv_i(rail_uv), .ctrl_i(ctrl),
    .rail_en_o(rail_en), .batt_good_o(batt_good), .cpu_rst_no(cpu_rst_n),
    .logic_rst_o(logic_rst), .ctrl_o(ctrl_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rail_en", rail_en, 0);
    chk("R1 batt_good", batt_good, 0);
    chk("R1 cpu_rst_n", cpu_rst_n, 0);
    chk("R1 logic_rst", logic_rst, 1);
    chk("R1 ctrl_o", ctrl_q, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release rail_en", rail_en, 0);
    chk("R1 after release cpu_rst_n", cpu_rst_n, 0);
  endtask

  task automatic t_batt_release();
    batt_low = 1'b0;
    step(2);
    chk("R2 latency rail_en", rail_en, 0);
    chk("R2 latency batt_good", batt_good, 0);
    step(1);
    chk("R4 rail_en", rail_en, 1);
    chk("R4 batt_good", batt_good, 1);
  endtask

  task automatic t_release_delay();
    rail_uv = 1'b0;
    step(1 + D);
    chk("R7 still held", cpu_rst_n, 0);
    chk("R10 ctrl blocked", ctrl_q, 0);
    chk("R10 logic_rst held", logic_rst, 1);
    step(1);
    chk("R7 released", cpu_rst_n, 1);
    chk("R10 logic_rst free", logic_rst, 0);
    chk("R10 ctrl passes", ctrl_q, 4'hA);
    ctrl = 4'h5;
    #1;
    chk("R10 ctrl follows", ctrl_q, 4'h5);
  endtask

  task automatic t_vin_ov();
    vin_ov = 1'b1;
    step(3);
    chk("R5 rail off", rail_en, 0);
    chk("R5 batt_good kept", batt_good, 1);
    vin_ov = 1'b0;
    step(3);
    chk("R5 rail back", rail_en, 1);
  endtask

  task automatic t_rail_ov_retry();
    for (int i = 0; i < 3; i++) begin
      rail_ov = 1'b1;
      step(3);
      chk("R6 rail off", rail_en, 0);
      rail_ov = 1'b0;
      step(3);
      chk("R6 rail retry on", rail_en, 1);
    end
  endtask

  task automatic t_uv_drop();
    rail_uv = 1'b1;
    step(2);
    chk("R8 not yet", cpu_rst_n, 1);
    step(1);
    chk("R8 reset asserted", cpu_rst_n, 0);
    chk("R10 ctrl blocked again", ctrl_q, 0);
  endtask

  task automatic t_restart();
    rail_uv = 1'b0;
    step(D / 2);
    rail_uv = 1'b1;
    step(3);
    rail_uv = 1'b0;
    step(1 + D);
    chk("R9 restarted count held", cpu_rst_n, 0);
    step(1);
    chk("R9 released after full count", cpu_rst_n, 1);
  endtask

  task automatic t_batt_drop();
    batt_low = 1'b1;
    step(3);
    chk("R3 batt_good low", batt_good, 0);
    chk("R3 rail off", rail_en, 0);
    chk("R3 reset unaffected", cpu_rst_n, 1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    t_batt_release();
    t_release_delay();
    t_vin_ov();
    t_rail_ov_retry();
    t_uv_drop();
    t_restart();
    t_batt_drop();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule